// File: doc/BRIEF.md
# Grouped Digital I/O Port with Edge Interrupts

This block drives and observes eight general-purpose lines through a single 16-bit control register. The lines form two groups of four, low (lines 0 to 3) and high (lines 4 to 7). Each group is made an input or an output as a whole. The low byte of the control register sets the levels driven on output lines. When the register is read, the low byte returns the current level of every line. Tristate pads are modelled as one output-value vector and one output-enable vector.

Every line has an edge detector that runs on a two-flop synchronized copy of its pin. Each low-group line has its own polarity bit. The four high-group lines share one polarity bit. A detected edge on line x sets bit 8+x of a sticky status register, and software clears a bit by writing one to it. An enable register with the same bit layout selects which status bits drive the registered interrupt output. Software reaches the three registers through a simple strobed read/write port. Read data is registered and is marked by a valid pulse.

Top module: `gdio_port`

## Requirements
- R1: After synchronous reset, the control, enable and status registers are zero. All lines are inputs (pad_oe = 0x00), pad_out = 0x00 and irq = 0.
- R2: Control bit 10 set drives pad_oe[3:0] to all ones. Control bit 11 set drives pad_oe[7:4] to all ones. A clear bit makes that group input.
- R3: pad_out equals control bits 7:0 starting the cycle after the write.
- R4: Reading the control register (address 0) returns stored bits 15:10 and 8 in place, and bit 9 reads 0. Bits 7:0 return the line levels: the driven value for an output line, and the synchronized pin for an input line.
- R5: For line x in 0..3, control bit 12+x selects the edge that sets status bit 8+x: 0 selects rising, 1 selects falling. The other edge sets nothing.
- R6: Lines 4..7 all use control bit 8 as their edge select (0 rising, 1 falling). An edge sets status bit 8+x.
- R7: Writing the status register (address 2) clears each bit 15:8 written as one and leaves bits written as zero unchanged. Status bits stay set until cleared.
- R8: irq is high exactly one cycle after any status bit is set whose enable bit is also set.
- R9: The enable register (address 1) stores only bits 15:8. Bits 7:0 of the enable and status registers read as zero.
- R10: A pin change made before rising edge k is visible in the status register from edge k+2 on, and not at edge k+1.
- R11: A read strobe on edge k yields bus_rdata with bus_rvalid high after edge k+1. bus_rvalid is low in cycles without a preceding read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 2 | Register select: 0 control, 1 enable, 2 status |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| bus_rvalid | output | 1 | Read data valid, one cycle after bus_rd |
| pad_in | input | 8 | Pin levels seen at the pads |
| pad_out | output | 8 | Values driven on output lines |
| pad_oe | output | 8 | Per-line output enable |
| irq | output | 1 | Registered interrupt request |

## Verification
Register writes change pad_out and pad_oe one edge after the strobe. The bench samples them on the following falling edge. A pin change reaches the status register on the third rising edge after it is applied: two synchronizer flops, one compare stage and the status flop. irq follows one edge after that. The bench reads status twice back to back, straddling that edge, to confirm the exact latency. For every other edge check it waits at least five cycles before reading. Read results are queued when the strobe is issued. A monitor pops and compares them on the falling edge where bus_rvalid is high.

// File: rtl/gdio_pkg.sv
package gdio_pkg;
  localparam int unsigned REG_W       = 16;
  localparam int unsigned LINES       = 8;
  localparam int unsigned GROUP       = 4;
  localparam int unsigned NGRP        = LINES / GROUP;
  localparam int unsigned POL_HI_BIT  = 8;
  localparam int unsigned OE_BASE     = 10;
  localparam int unsigned POL_LO_BASE = 12;

  typedef enum logic [1:0] {
    A_CTRL  = 2'd0,
    A_IRQEN = 2'd1,
    A_IRQST = 2'd2
  } reg_addr_e;
endpackage

// File: rtl/gdio_edge.sv
module gdio_edge #(
  parameter int unsigned N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] pad,
  input  logic [N-1:0] fall_sel,
  output logic [N-1:0] level,
  output logic [N-1:0] hit
);
  logic [N-1:0] s1, s2, prev;
  logic [2:0]   warm;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1   <= '0;
      s2   <= '0;
      prev <= '0;
      warm <= '0;
    end else begin
      s1   <= pad;
      s2   <= s1;
      prev <= s2;
      warm <= {warm[1:0], 1'b1};
    end
  end

  assign level = s2;

  for (genvar i = 0; i < N; i++) begin : g_det
    assign hit[i] = warm[2] &
                    (fall_sel[i] ? (prev[i] & ~s2[i]) : (~prev[i] & s2[i]));
  end
endmodule

// File: rtl/gdio_irq.sv
module gdio_irq #(
  parameter int unsigned N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] hit,
  input  logic         en_wr,
  input  logic         st_wr,
  input  logic [N-1:0] wbits,
  output logic [N-1:0] en,
  output logic [N-1:0] stat,
  output logic         irq
);
  logic [N-1:0] clr;
  assign clr = st_wr ? wbits : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      en   <= '0;
      stat <= '0;
      irq  <= 1'b0;
    end else begin
      if (en_wr) en <= wbits;
      stat <= (stat & ~clr) | hit;
      irq  <= |(stat & en);
    end
  end

  // R7: a cleared bit without a concurrent edge is zero afterwards
  p_w1c_r7: assert property (@(posedge clk) disable iff (rst)
    st_wr |=> ((stat & $past(wbits & ~hit)) == '0));

  // R7: bits not cleared stay set
  p_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((stat & $past(stat & ~clr)) == $past(stat & ~clr)));

  // R8: no request without an enabled pending bit in the previous cycle
  p_irq_low_r8: assert property (@(posedge clk) disable iff (rst)
    !(|(stat & en)) |=> !irq);
endmodule

// File: rtl/gdio_port.sv
module gdio_port
  import gdio_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [1:0]  bus_addr,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  output logic        bus_rvalid,
  input  logic [7:0]  pad_in,
  output logic [7:0]  pad_out,
  output logic [7:0]  pad_oe,
  output logic        irq
);
  localparam int unsigned HI = REG_W - LINES;

  logic [LINES-1:0] out_val;
  logic [NGRP-1:0]  grp_oe;
  logic             pol_hi;
  logic [GROUP-1:0] pol_lo;
  logic [LINES-1:0] fall_sel, level, hit, en, stat, seen;
  logic             ctrl_wr, en_wr, st_wr;

  assign ctrl_wr = bus_wr && (bus_addr == A_CTRL);
  assign en_wr   = bus_wr && (bus_addr == A_IRQEN);
  assign st_wr   = bus_wr && (bus_addr == A_IRQST);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_val <= '0;
      grp_oe  <= '0;
      pol_hi  <= 1'b0;
      pol_lo  <= '0;
    end else if (ctrl_wr) begin
      out_val <= bus_wdata[LINES-1:0];
      grp_oe  <= bus_wdata[OE_BASE +: NGRP];
      pol_hi  <= bus_wdata[POL_HI_BIT];
      pol_lo  <= bus_wdata[POL_LO_BASE +: GROUP];
    end
  end

  for (genvar i = 0; i < LINES; i++) begin : g_line
    assign pad_oe[i] = grp_oe[i / GROUP];
    if (i < GROUP) begin : g_own
      assign fall_sel[i] = pol_lo[i];
    end else begin : g_shared
      assign fall_sel[i] = pol_hi;
    end
  end

  assign pad_out = out_val;
  assign seen    = (pad_oe & out_val) | (~pad_oe & level);

  gdio_edge #(.N(LINES)) u_edge (
    .clk(clk), .rst(rst), .pad(pad_in), .fall_sel(fall_sel),
    .level(level), .hit(hit)
  );

  gdio_irq #(.N(LINES)) u_irq (
    .clk(clk), .rst(rst), .hit(hit), .en_wr(en_wr), .st_wr(st_wr),
    .wbits(bus_wdata[REG_W-1 -: LINES]), .en(en), .stat(stat), .irq(irq)
  );

  logic [REG_W-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      A_CTRL: begin
        rd_mux[LINES-1:0]             = seen;
        rd_mux[POL_HI_BIT]            = pol_hi;
        rd_mux[OE_BASE +: NGRP]       = grp_oe;
        rd_mux[POL_LO_BASE +: GROUP]  = pol_lo;
      end
      A_IRQEN: rd_mux[REG_W-1 -: HI] = en;
      A_IRQST: rd_mux[REG_W-1 -: HI] = stat;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= bus_rd;
      if (bus_rd) bus_rdata <= rd_mux;
    end
  end

  // R3: output value follows the control write
  p_dout_follows_r3: assert property (@(posedge clk) disable iff (rst)
    ctrl_wr |=> (pad_out == $past(bus_wdata[LINES-1:0])));

  // R11: every read strobe is answered in the next cycle
  p_rvalid_r11: assert property (@(posedge clk) disable iff (rst)
    bus_rd |=> bus_rvalid);
endmodule

// File: tb/gdio_port_tb.sv
module gdio_port_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        bus_rvalid;
  logic [7:0]  pad_in = '0;
  logic [7:0]  pad_out, pad_oe;
  logic        irq;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;
  logic [15:0] exp_q[$];
  string       tag_q[$];

  always #5 clk = ~clk;

  gdio_port u_dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .pad_in(pad_in), .pad_out(pad_out),
    .pad_oe(pad_oe), .irq(irq)
  );

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [15:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, logic [15:0] exp, string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: compare queued read results when they are valid
  always @(negedge clk) begin
    if (!rst && bus_rvalid) begin
      if (exp_q.size() == 0) begin
        n_run++; n_fail++;
        $display("FAIL R11: unexpected read data %h expected none", bus_rdata);
      end else begin
        chk(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    idle(4);
    rst = 1'b0;
    idle(1);
    // R1 reset state
    chk("R1 oe", {8'h0, pad_oe}, 16'h0000);
    chk("R1 out", {8'h0, pad_out}, 16'h0000);
    chk("R1 irq", {15'h0, irq}, 16'h0000);
    chk("R11 idle rvalid", {15'h0, bus_rvalid}, 16'h0000);
    rd(2'd0, 16'h0000, "R1 ctrl");
    rd(2'd1, 16'h0000, "R1 enable");
    rd(2'd2, 16'h0000, "R1 status");
    // R2/R3/R4 both groups output, bit 9 not stored
    wr(2'd0, 16'h0EA5);
    chk("R2 oe both", {8'h0, pad_oe}, 16'h00FF);
    chk("R3 out", {8'h0, pad_out}, 16'h00A5);
    rd(2'd0, 16'h0CA5, "R4 ctrl outputs");
    // low group out, high group in
    wr(2'd0, 16'h0405);
    chk("R2 oe low", {8'h0, pad_oe}, 16'h000F);
    chk("R3 out", {8'h0, pad_out}, 16'h0005);
    pad_in = 8'hF0;
    idle(5);
    rd(2'd0, 16'h04F5, "R4 mixed levels");
    rd(2'd2, 16'hF000, "R6 rising high group");
    // R7 write-one-to-clear
    wr(2'd2, 16'h3000);
    rd(2'd2, 16'hC000, "R7 partial clear");
    wr(2'd2, 16'h0000);
    rd(2'd2, 16'hC000, "R7 zero write");
    wr(2'd2, 16'hC000);
    rd(2'd2, 16'h0000, "R7 full clear");
    // R6 falling on high group
    wr(2'd0, 16'h0100);
    pad_in = 8'h00;
    idle(5);
    rd(2'd2, 16'hF000, "R6 falling high group");
    wr(2'd2, 16'hF000);
    // R10 latency, R5 rising
    pad_in = 8'h0F;
    idle(2);
    rd(2'd2, 16'h0000, "R10 not yet");
    rd(2'd2, 16'h0F00, "R10 R5 rising low group");
    wr(2'd2, 16'h0F00);
    // R5 per-line polarity
    wr(2'd0, 16'hA000);
    rd(2'd0, 16'hA00F, "R4 input levels");
    pad_in = 8'h00;
    idle(5);
    rd(2'd2, 16'h0A00, "R5 falling lines 1 3");
    pad_in = 8'h0F;
    idle(5);
    rd(2'd2, 16'h0F00, "R5 rising lines 0 2");
    wr(2'd2, 16'h0F00);
    // R9 / R8 interrupt
    wr(2'd1, 16'h02FF);
    rd(2'd1, 16'h0200, "R9 enable low byte");
    chk("R8 irq idle", {15'h0, irq}, 16'h0000);
    pad_in = 8'h0D;
    idle(6);
    chk("R8 irq raised", {15'h0, irq}, 16'h0001);
    rd(2'd2, 16'h0200, "R5 line1 status");
    wr(2'd2, 16'h0200);
    idle(3);
    chk("R8 irq cleared", {15'h0, irq}, 16'h0000);
    pad_in = 8'h0C;
    idle(5);
    pad_in = 8'h0D;
    idle(6);
    chk("R8 irq masked", {15'h0, irq}, 16'h0000);
    rd(2'd2, 16'h0100, "R5 line0 rising only");
    // R2 high group alone
    wr(2'd0, 16'h0800);
    chk("R2 oe high", {8'h0, pad_oe}, 16'h00F0);
    idle(3);
    chk("R11 queue drained", 16'(exp_q.size()), 16'h0000);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule